// File: doc/BRIEF.md
# Adaptive dead-time gate controller

This block turns a single PWM command into two gate enables for a half-bridge: one for the high-side switch and one for the low-side switch. While the block is enabled, the high-side enable tracks the command and the low-side enable tracks its inverse. Every change of side passes through a both-off interval, so the two switches are never on together.

The dead time is not fixed. When the high side is turned off, the low side waits for a comparator flag that reports the switch node below a low threshold. The node must first be seen above that threshold and then seen below it. If the node was never seen above the threshold, a shorter fixed delay applies. If the node rose but never comes back down, a hard timeout turns the low side on anyway. When the low side is turned off, the high side waits for a flag that reports the low-side gate voltage as discharged, and then adds a fixed delay.

An active-low halt input forces both enables low and parks the controller in an idle both-off state. On release, the controller performs an ordinary handover to the side the command selects. All four inputs pass through two-flop synchronizers. All delays are counted in clock cycles.

Top module: `gate_handover_ctrl`

## Requirements
- R1: Once a handover is complete, `hs_en` is high only if `pwm_in` and `halt_n` were both high as sampled three clock edges earlier, and `ls_en` is high only if `pwm_in` was low and `halt_n` high as sampled then. Three edges are two synchronizer stages plus the state register.
- R2: A low `halt_n` forces both enables low three edges after it is sampled, and holds them low for as long as it stays low, whatever `pwm_in` does.
- R3: A falling `pwm_in` turns `hs_en` off three edges after it is sampled. `ls_en` stays low at least until the next edge.
- R4: If the switch node was seen high (`sw_low` = 0) during the wait and `sw_low` then returns to 1, `ls_en` rises three edges after that rise of `sw_low` is sampled.
- R5: If `sw_low` stays 1 for the whole wait, `ls_en` rises exactly FIXED_DLY cycles after `hs_en` falls.
- R6: If the switch node is seen high and never falls back, `ls_en` rises exactly TIMEOUT_DLY cycles after `hs_en` falls.
- R7: A rising `pwm_in` turns `ls_en` off three edges after it is sampled. If `lsg_low` is already 1, `hs_en` rises exactly LS_TO_HS_DLY cycles after `ls_en` falls.
- R8: While `lsg_low` stays 0, `hs_en` stays low. Once a 1 on `lsg_low` is sampled, `hs_en` rises LS_TO_HS_DLY + 2 cycles after the edge before that sample.
- R9: If `pwm_in` reverses during a pending handover, that handover is abandoned and the opposite handover restarts its timing from zero. The abandoned side is never enabled.
- R10: `hs_en` and `ls_en` are never high in the same cycle.
- R11: During reset and right after it, both enables are low.
- R12: When `halt_n` is released, the controller performs a normal handover to the side `pwm_in` selects. With `pwm_in` = 1 and `lsg_low` = 1, `hs_en` rises LS_TO_HS_DLY + 3 cycles after the release is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command: 1 selects the high side, 0 selects the low side |
| halt_n | input | 1 | Active-low output disable |
| sw_low | input | 1 | Comparator flag, 1 while the switch node is below its low threshold |
| lsg_low | input | 1 | Flag, 1 once the low-side gate sense is below its threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach is a reversal of the command part-way through a pending handover. It needs a command edge to arrive after the high side is off, while the switch-node wait is still running, and before either the fixed delay or the timeout expires. The directed stimulus produces it by driving the switch node high and holding it there, which keeps the low side waiting on the long timeout, and then flipping `pwm_in` a few cycles into that wait. Separate directed runs pin down the three exit paths of the switch-node wait, the gate-sense stall, and the release from halt. A long random run with slow command toggling and fast flag toggling then checks the phase relation and the mutual exclusion on every cycle.

// File: rtl/ghc_pkg.sv
// Package: shared types for the gate handover controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ghc_pkg;
    // Controller states. The two output-active states are the only ones that drive a gate.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_ON   = 3'd1,
        ST_LS_ON   = 3'd2,
        ST_WAIT_LS = 3'd3,
        ST_WAIT_HS = 3'd4
    } ghc_state_t;
endpackage

// File: rtl/ghc_sync.sv
// Module: multi-bit level synchronizer, STAGES flops per bit.
// Assumes each bit is an independent slow level. No bus coherency is implied.
// Resets to all zeros, so the active-low halt input reads as halted until it is synchronized.
module ghc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_in;
    end

    // Remaining stages settle any metastability.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/ghc_timer.sv
// Module: wait counter shared by both handover directions.
// Assumes clear has priority over step. The owner never steps the counter past its largest limit.
module ghc_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    // Count the cycles spent in the current wait state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (step)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ghc_fsm.sv
// Module: non-overlap state machine with adaptive high-to-low and gated low-to-high handover.
// Assumes synchronized inputs, FIXED_DLY < TIMEOUT_DLY, and every delay >= 1.
// Gate enables are registered from the next state, so they cannot glitch.
module ghc_fsm
    import ghc_pkg::*;
#(
    parameter int unsigned FIXED_DLY    = 19,
    parameter int unsigned TIMEOUT_DLY  = 24,
    parameter int unsigned LS_TO_HS_DLY = 4,
    parameter int unsigned CNT_W        = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_s,
    input  logic en_s,
    input  logic swl_s,
    input  logic gl_s,
    output logic hs_q,
    output logic ls_q
);
    localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIXED_DLY - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_DLY - 1);
    localparam logic [CNT_W-1:0] L2H_LAST = CNT_W'(LS_TO_HS_DLY - 1);

    ghc_state_t       state_q, state_d;
    logic             seen_q, seen_d;
    logic             armed_q, armed_d;
    logic             seen_now, armed_now;
    logic             tmr_clr, tmr_step;
    logic [CNT_W-1:0] cnt;

    ghc_timer #(.CNT_W(CNT_W)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .step (tmr_step),
        .cnt  (cnt)
    );

    assign seen_now  = seen_q | ~swl_s;
    assign armed_now = armed_q | gl_s;

    // Next-state, qualifier and timer control for both handover directions.
    always_comb begin
        state_d  = state_q;
        seen_d   = seen_q;
        armed_d  = armed_q;
        tmr_step = 1'b0;
        if (!en_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = pwm_s ? ST_WAIT_HS : ST_WAIT_LS;
                ST_HS_ON: if (!pwm_s) state_d = ST_WAIT_LS;
                ST_LS_ON: if (pwm_s)  state_d = ST_WAIT_HS;
                ST_WAIT_LS: begin
                    if (pwm_s) begin
                        state_d = ST_WAIT_HS;
                    end else if ((seen_q && swl_s) ||
                                 (!seen_now && cnt == FIX_LAST) ||
                                 (cnt == TO_LAST)) begin
                        state_d = ST_LS_ON;
                    end else begin
                        tmr_step = 1'b1;
                        seen_d   = seen_now;
                    end
                end
                ST_WAIT_HS: begin
                    if (!pwm_s) begin
                        state_d = ST_WAIT_LS;
                    end else if (armed_now) begin
                        if (cnt == L2H_LAST) begin
                            state_d = ST_HS_ON;
                        end else begin
                            tmr_step = 1'b1;
                            armed_d  = 1'b1;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (state_d != state_q) begin
            seen_d  = 1'b0;
            armed_d = 1'b0;
        end
    end

    assign tmr_clr = (state_d != state_q);

    // State, qualifiers and registered gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
            hs_q    <= 1'b0;
            ls_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
            armed_q <= armed_d;
            hs_q    <= (state_d == ST_HS_ON);
            ls_q    <= (state_d == ST_LS_ON);
        end
    end

    // R2: a halted cycle leaves both gates off on the next edge.
    assert_off_when_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!hs_q && !ls_q));

    // R1: an enabled high side traces back to an enabled high command.
    assert_hs_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |-> ($past(pwm_s) && $past(en_s)));

    // R1: an enabled low side traces back to an enabled low command.
    assert_ls_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q |-> (!$past(pwm_s) && $past(en_s)));

    // R3: the low side only turns on after a cycle with the high side off.
    assert_ls_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_q) |-> !$past(hs_q));

    // R7: the high side only turns on after a cycle with the low side off.
    assert_hs_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> !$past(ls_q));

    // R6: the switch-node wait never runs past its timeout.
    assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LS) |-> (cnt < CNT_W'(TIMEOUT_DLY)));
endmodule

// File: rtl/gate_handover_ctrl.sv
// Module: top of the adaptive dead-time gate controller.
// Synchronizes the four asynchronous inputs and feeds the non-overlap state machine.
// Assumes delays are given in cycles of clk, with FIXED_DLY < TIMEOUT_DLY.
module gate_handover_ctrl #(
    parameter int unsigned FIXED_DLY    = 19,
    parameter int unsigned TIMEOUT_DLY  = 24,
    parameter int unsigned LS_TO_HS_DLY = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic halt_n,
    input  logic sw_low,
    input  logic lsg_low,
    output logic hs_en,
    output logic ls_en
);
    localparam int unsigned MAX_DLY = (TIMEOUT_DLY > LS_TO_HS_DLY) ? TIMEOUT_DLY : LS_TO_HS_DLY;
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

    logic [3:0] raw_in, sync_out;

    assign raw_in = {pwm_in, halt_n, sw_low, lsg_low};

    ghc_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (raw_in),
        .d_out(sync_out)
    );

    ghc_fsm #(
        .FIXED_DLY   (FIXED_DLY),
        .TIMEOUT_DLY (TIMEOUT_DLY),
        .LS_TO_HS_DLY(LS_TO_HS_DLY),
        .CNT_W       (CNT_W)
    ) fsm_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pwm_s(sync_out[3]),
        .en_s (sync_out[2]),
        .swl_s(sync_out[1]),
        .gl_s (sync_out[0]),
        .hs_q (hs_en),
        .ls_q (ls_en)
    );
endmodule

// File: tb/gate_handover_ctrl_tb_top.sv
`timescale 1ns/1ps
module gate_handover_ctrl_tb_top;
    localparam int FIX = 19;
    localparam int TO  = 24;
    localparam int L2H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0, halt_n = 1'b1, sw_low = 1'b1, lsg_low = 1'b1;
    logic hs_en, ls_en;

    int n_chk = 0, n_fail = 0;
    bit prop_on = 1'b0, done = 1'b0;
    logic [2:0] h_pwm = '0, h_halt = '0;

    always #4 clk = ~clk;

    gate_handover_ctrl #(.FIXED_DLY(FIX), .TIMEOUT_DLY(TO), .LS_TO_HS_DLY(L2H)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .halt_n(halt_n),
        .sw_low(sw_low), .lsg_low(lsg_low), .hs_en(hs_en), .ls_en(ls_en)
    );

    function automatic bit hs_allowed(logic p, logic h);
        return p && h;
    endfunction

    function automatic bit ls_allowed(logic p, logic h);
        return !p && h;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Input history sampled on each edge: index 2 is the value taken three edges back.
    always @(posedge clk) begin
        h_pwm  <= {h_pwm[1:0], pwm_in};
        h_halt <= {h_halt[1:0], halt_n};
    end

    // Checks run on every cycle: mutual exclusion and phase against the delayed inputs.
    always @(negedge clk) begin
        if (prop_on) begin
            chk("R10 overlap", int'(hs_en && ls_en), 0);
            if (hs_en) chk("R1 hs phase", int'(hs_allowed(h_pwm[2], h_halt[2])), 1);
            if (ls_en) chk("R1 ls phase", int'(ls_allowed(h_pwm[2], h_halt[2])), 1);
            if (!h_halt[2]) chk("R2 halted", int'(hs_en | ls_en), 0);
        end
    end

    task automatic count_until_hs(inout int n, inout bit ls_seen);
        while (!hs_en && n < 300) begin
            n++;
            if (ls_en) ls_seen = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic count_until_ls(inout int n);
        while (!ls_en && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_hs_fall();
        for (int k = 0; k < 20 && hs_en; k++) @(negedge clk);
    endtask

    initial begin
        int n;
        bit lseen;
        void'($urandom(32'h1a2b3c4d));
        repeat (5) @(negedge clk);
        chk("R11 reset hs", int'(hs_en), 0);
        chk("R11 reset ls", int'(ls_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", int'(hs_en | ls_en), 0);
        repeat (3) @(negedge clk);
        prop_on = 1'b1;
        repeat (40) @(negedge clk);
        chk("R12 start on low side", int'(ls_en), 1);
        chk("R1 low cmd hs", int'(hs_en), 0);

        // R7: low-to-high with the gate sense already low.
        pwm_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 ls still on", int'(ls_en), 1);
        @(negedge clk);
        chk("R7 ls off", int'(ls_en), 0);
        n = 0; lseen = 0;
        count_until_hs(n, lseen);
        chk("R7 gap", n, L2H);

        // R4: adaptive path, node high then falling three cycles into the wait.
        sw_low = 1'b0; lsg_low = 1'b0;
        repeat (6) @(negedge clk);
        pwm_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3 hs still on", int'(hs_en), 1);
        @(negedge clk);
        chk("R3 hs off", int'(hs_en), 0);
        chk("R3 ls not yet", int'(ls_en), 0);
        n = 0;
        repeat (3) begin n++; @(negedge clk); end
        sw_low = 1'b1;
        count_until_ls(n);
        chk("R4 adaptive gap", n, 6);

        // R8: gate sense stays high, so the high side must wait.
        pwm_in = 1'b1;
        repeat (50) @(negedge clk);
        chk("R8 hs held off", int'(hs_en), 0);
        chk("R8 ls off", int'(ls_en), 0);
        lsg_low = 1'b1;
        n = 0; lseen = 0;
        count_until_hs(n, lseen);
        chk("R8 release gap", n, L2H + 2);

        // R5: the node never rises, so the fixed delay applies.
        repeat (5) @(negedge clk);
        pwm_in = 1'b0;
        wait_hs_fall();
        n = 0;
        count_until_ls(n);
        chk("R5 fixed gap", n, FIX);

        // R6: the node rises and stays high, so the timeout applies.
        pwm_in = 1'b1;
        repeat (15) @(negedge clk);
        sw_low = 1'b0;
        repeat (5) @(negedge clk);
        pwm_in = 1'b0;
        wait_hs_fall();
        n = 0;
        count_until_ls(n);
        chk("R6 timeout gap", n, TO);

        // R9: command reverses while the low side is still waiting.
        pwm_in = 1'b1;
        repeat (15) @(negedge clk);
        pwm_in = 1'b0;
        wait_hs_fall();
        n = 0; lseen = 0;
        repeat (3) begin n++; @(negedge clk); end
        pwm_in = 1'b1;
        count_until_hs(n, lseen);
        chk("R9 abort gap", n, 6 + L2H);
        chk("R9 ls never on", int'(lseen), 0);

        // R2: halt forces both off, whatever the command does.
        halt_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 hs before latency", int'(hs_en), 1);
        @(negedge clk);
        chk("R2 both off", int'(hs_en | ls_en), 0);
        for (int k = 0; k < 30; k++) begin
            if (k % 7 == 0) pwm_in = ~pwm_in;
            @(negedge clk);
        end
        chk("R2 still off", int'(hs_en | ls_en), 0);

        // R12: release with a high command resumes through a normal handover.
        pwm_in = 1'b1; lsg_low = 1'b1;
        repeat (5) @(negedge clk);
        halt_n = 1'b1;
        n = 0; lseen = 0;
        count_until_hs(n, lseen);
        chk("R12 resume gap", n, L2H + 3);
        chk("R12 no low side", int'(lseen), 0);

        // Random phase: slow command, fast flags, rare halts. Per-cycle checks run meanwhile.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom % 40 == 0) pwm_in = ~pwm_in;
            if ($urandom % 6 == 0) sw_low = ~sw_low;
            if ($urandom % 5 == 0) lsg_low = ~lsg_low;
            if ($urandom % 400 == 0) halt_n = ~halt_n;
        end
        halt_n = 1'b1;
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule